// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full and Almost-Empty Flags

This block is a first-in first-out buffer for 36-bit words. A producer writes on one clock and a consumer reads on an unrelated clock. Each side keeps its own pointer. The pointers cross between the two domains as Gray code through two-flop synchronizers. Those synchronized copies drive the internal full check, the read-side data-available indication and the read-clock-only version of the almost-empty flag.

Two status flags are produced, and both are active low. The half-full flag and the asynchronous almost-empty flag are decoded directly from the live write pointer and the live consumed-word count. A write edge can therefore drop the half-full flag at once, and a read edge can raise it at once. The almost-empty flag can also be built as a read-clock register fed from the synchronized write pointer.

The consumer picks one of two read styles while master reset is asserted:
- **Standard style:** a read request fetches the next word.
- **Fall-through style:** the oldest word is presented without any request. In this style the output register holds one extra word, so the half-full threshold is one word higher.

Partial reset empties the buffer and keeps the configuration that master reset captured.

Top module: `fifoFlagTop`

## Requirements
- R1: While mrstN is low, the read style (cfgFwft), the almost-empty style (cfgAeAsync) and the offset (cfgAeOffset) are captured on rdClk. Either reset (mrstN or prstN low) empties the buffer, giving hfN=1, aeN=0 and emptyN=0. Partial reset keeps the captured configuration.
- R2: Standard style (cfgFwft=0). rdEn sampled high on a rdClk rising edge while emptyN is high consumes the oldest word and shows it on rdData after that edge. rdEn while emptyN is low changes nothing.
- R3: Fall-through style (cfgFwft=1). The oldest word appears on rdData with emptyN high, without any rdEn. rdEn while emptyN is high consumes that word, and the following word is presented next.
- R4: Occupancy is accepted writes minus consumed words. wrEn is accepted only while memory holds fewer than DEPTH words; otherwise the write is ignored and no word is stored.
- R5: Standard style: hfN goes low right after the wrClk edge that makes occupancy exceed DEPTH/2. With no reads, that is the (DEPTH/2+1)-th write.
- R6: Fall-through style: hfN goes low when occupancy exceeds DEPTH/2+1. With no reads, that is the (DEPTH/2+2)-th write.
- R7: hfN returns high right after the rdClk edge that brings occupancy down to the threshold of the active style.
- R8: With cfgAeAsync=1, aeN is low while occupancy is less than or equal to the offset. It is asserted right after a rdClk edge and released right after a wrClk edge.
- R9: With cfgAeAsync=0, aeN is a rdClk register computed from the synchronized write pointer. A write does not change aeN before later rdClk edges, and aeN settles within six rdClk cycles.
- R10: After a write into an empty buffer, emptyN rises within five rdClk cycles in either read style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock, unrelated to wrClk |
| mrstN | input | 1 | Master reset, active low; clears pointers and captures configuration |
| prstN | input | 1 | Partial reset, active low; clears pointers only |
| cfgFwft | input | 1 | Read style captured at master reset: 0 standard, 1 fall-through |
| cfgAeAsync | input | 1 | Almost-empty style captured at master reset: 1 dual-clock, 0 read-clock only |
| cfgAeOffset | input | $clog2(DEPTH) | Almost-empty offset captured at master reset |
| wrEn | input | 1 | Write request |
| wrData | input | DW | Write word |
| rdEn | input | 1 | Read request |
| rdData | output | DW | Read word |
| emptyN | output | 1 | High when a word can be read (standard) or is presented (fall-through) |
| hfN | output | 1 | Half-full flag, active low |
| aeN | output | 1 | Almost-empty flag, active low |

## Verification
The bench runs four input patterns:
- **Rising fill with no reads, in each style.** This shows the exact write count at which hfN drops. It separates the DEPTH/2+1 threshold from the DEPTH/2+2 threshold.
- **Draining reads.** These show that hfN and the dual-clock aeN move on the read edge itself, and that words leave in order.
- **A write against a full memory and a read against an empty one.** Each of these must leave no trace in the later word stream.
- **The read-clock-only almost-empty style, sampled right after a write.** A flag wrongly built from the live write pointer would already have moved at that point, so this check tells the two builds apart.

// File: rtl/fifoFlagPkg.sv
package fifoFlagPkg;

  // Read style captured at master reset
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FALLTHRU = 1'b1
  } rdStyle_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWrite;   // wrClk domain: store wrData at wrAddr
    logic outLoad;    // rdClk domain: load output register from rdAddr
  } dpStrobe_t;

endpackage

// File: rtl/ptrSync.sv
// Two-flop synchronizer for a Gray-coded pointer, with binary output
module ptrSync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign binOut[i] = ^stage2[W-1:i];
  end
endmodule

// File: rtl/fifoDatapath.sv
// Storage array and output register
module fifoDatapath
  import fifoFlagPkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.outLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/fifoCtrl.sv
// Pointers, domain crossing, read-style sequencing and status flags
module fifoCtrl
  import fifoFlagPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          mrstN,
  input  logic          cfgFwftIn,
  input  logic          cfgAeAsyncIn,
  input  logic [AW-1:0] cfgAeOffsetIn,
  input  logic          wrEn,
  input  logic          rdEn,
  output dpStrobe_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          hfN,
  output logic          aeN
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  // ---------------- configuration (captured during master reset) -------
  rdStyle_t      rdStyle;
  logic          aeAsync;
  logic [AW-1:0] aeOffset;

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      rdStyle  <= rdStyle_t'(cfgFwftIn);
      aeAsync  <= cfgAeAsyncIn;
      aeOffset <= cfgAeOffsetIn;
    end
  end

  // ---------------- write domain ----------------------------------------
  logic [PW-1:0] wrPtr, wrPtrNext, wrGray;
  logic [PW-1:0] rdGray, rdPtrSyncW;
  logic [PW-1:0] memCntW;
  logic          wrAccept;

  ptrSync #(.W(PW)) u_rdToWr (
    .clk   (wrClk),
    .rstN  (rstN),
    .grayIn(rdGray),
    .binOut(rdPtrSyncW)
  );

  always_comb begin
    memCntW   = wrPtr - rdPtrSyncW;
    wrAccept  = wrEn && (memCntW < DEPTH_P);
    wrPtrNext = wrPtr + PW'(1);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  // ---------------- read domain -----------------------------------------
  logic [PW-1:0] rdPtr, rdPtrNext, rdUsed, rdUsedNext;
  logic [PW-1:0] wrPtrSyncR, memCntR, occSync;
  logic          memHasWord, outValid, popUser, outLoad, aeSyncN;

  ptrSync #(.W(PW)) u_wrToRd (
    .clk   (rdClk),
    .rstN  (rstN),
    .grayIn(wrGray),
    .binOut(wrPtrSyncR)
  );

  always_comb begin
    memCntR    = wrPtrSyncR - rdPtr;
    memHasWord = (memCntR != '0);
    if (rdStyle == RD_FALLTHRU) begin
      outLoad = memHasWord && (!outValid || rdEn);
      popUser = rdEn && outValid;
    end else begin
      outLoad = rdEn && memHasWord;
      popUser = outLoad;
    end
    rdPtrNext  = rdPtr + PW'(outLoad);
    rdUsedNext = rdUsed + PW'(popUser);
    occSync    = wrPtrSyncR - rdUsedNext;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      rdUsed   <= '0;
      outValid <= 1'b0;
      aeSyncN  <= 1'b0;
    end else begin
      rdPtr    <= rdPtrNext;
      rdGray   <= rdPtrNext ^ (rdPtrNext >> 1);
      rdUsed   <= rdUsedNext;
      outValid <= (rdStyle == RD_FALLTHRU) && (outLoad || (outValid && !popUser));
      aeSyncN  <= !(occSync <= {1'b0, aeOffset});
    end
  end

  // ---------------- flags -----------------------------------------------
  logic [PW-1:0] occRaw, hfLimit;
  logic          aeAsyncN;

  always_comb begin
    // Live pointers from both domains: moves on either clock
    occRaw   = wrPtr - rdUsed;
    hfLimit  = (rdStyle == RD_FALLTHRU) ? HALF_P + PW'(1) : HALF_P;
    hfN      = !(occRaw > hfLimit);
    aeAsyncN = !(occRaw <= {1'b0, aeOffset});
    aeN      = aeAsync ? aeAsyncN : aeSyncN;
    emptyN   = (rdStyle == RD_FALLTHRU) ? outValid : memHasWord;
  end

  assign strb.memWrite = wrAccept;
  assign strb.outLoad  = outLoad;
  assign wrAddr        = wrPtr[AW-1:0];
  assign rdAddr        = rdPtr[AW-1:0];

  // ---------------- assertions ------------------------------------------
  // R4: the write side never sees more than DEPTH words in memory
  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    memCntW <= DEPTH_P);

  // R4: the read side never sees more than DEPTH words in memory
  p_rd_bound_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    memCntR <= DEPTH_P);

  // R2: a request against an empty buffer moves no pointer
  p_empty_read_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdStyle == RD_STANDARD && rdEn && !emptyN) |=> ($stable(rdPtr) && $stable(rdUsed)));

  // R3: a presented word stays presented until a request consumes it
  p_fwft_hold_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdStyle == RD_FALLTHRU && outValid && !rdEn) |=> outValid);

  // R3: consumed words trail fetched words by at most the output register
  p_used_lag_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdPtr - rdUsed) <= PW'(1));
endmodule

// File: rtl/fifoFlagTop.sv
module fifoFlagTop
  import fifoFlagPkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          cfgFwft,
  input  logic          cfgAeAsync,
  input  logic [AW-1:0] cfgAeOffset,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          emptyN,
  output logic          hfN,
  output logic          aeN
);
  logic          rstN;
  dpStrobe_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;

  assign rstN = mrstN & prstN;

  fifoCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk        (wrClk),
    .rdClk        (rdClk),
    .rstN         (rstN),
    .mrstN        (mrstN),
    .cfgFwftIn    (cfgFwft),
    .cfgAeAsyncIn (cfgAeAsync),
    .cfgAeOffsetIn(cfgAeOffset),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .strb         (strb),
    .wrAddr       (wrAddr),
    .rdAddr       (rdAddr),
    .emptyN       (emptyN),
    .hfN          (hfN),
    .aeN          (aeN)
  );

  fifoDatapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .strb  (strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: tb/sim_fifoFlagTop.sv
`timescale 1ns/1ps
module sim_fifoFlagTop;
  localparam int DW = 36;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1;
  logic cfgFwft = 1'b0, cfgAeAsync = 1'b1;
  logic [AW-1:0] cfgAeOffset = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic emptyN, hfN, aeN;

  always #2.0 wrClk = ~wrClk;   // 250 MHz
  always #3.5 rdClk = ~rdClk;   // unrelated read clock

  fifoFlagTop #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .cfgFwft(cfgFwft), .cfgAeAsync(cfgAeAsync), .cfgAeOffset(cfgAeOffset),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .emptyN(emptyN), .hfN(hfN), .aeN(aeN)
  );

  // Reference model
  int nRun = 0, nFail = 0;
  int occ = 0;
  logic [DW-1:0] q[$];
  bit fwftMode = 0, aeAsyncMode = 1;
  int aeOff = 0;
  int wordSeq = 0;

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkData(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int hfExp();
    int thr = fwftMode ? DEPTH/2 + 1 : DEPTH/2;
    return (occ > thr) ? 0 : 1;
  endfunction

  function automatic int aeExp();
    return (occ <= aeOff) ? 0 : 1;
  endfunction

  task automatic settleRd();
    repeat (6) @(posedge rdClk);
    #1;
  endtask

  task automatic doReset(bit fw, bit aeA, int off);
    @(negedge rdClk);
    mrstN = 1'b0; cfgFwft = fw; cfgAeAsync = aeA; cfgAeOffset = AW'(off);
    repeat (3) @(posedge rdClk);
    @(negedge rdClk);
    mrstN = 1'b1;
    q.delete(); occ = 0;
    fwftMode = fw; aeAsyncMode = aeA; aeOff = off;
    repeat (2) @(negedge rdClk);
    chk("R1 reset hfN", int'(hfN), 1);
    chk("R1 reset aeN", int'(aeN), 0);
    chk("R1 reset emptyN", int'(emptyN), 0);
  endtask

  task automatic wrWord();
    logic [DW-1:0] d = {4'hA, 32'(wordSeq * 32'h0101_0107 + 5)};
    wordSeq++;
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(posedge wrClk);
    #1;
    wrEn = 1'b0;
    if (occ < DEPTH) begin
      q.push_back(d);
      occ++;
    end
    chk(fwftMode ? "R6 hfN after write" : "R5 hfN after write", int'(hfN), hfExp());
    if (aeAsyncMode) chk("R8 aeN released on write edge", int'(aeN), aeExp());
  endtask

  task automatic waitData(string tag);
    int n = 0;
    do begin
      @(negedge rdClk);
      n++;
    end while (!emptyN && n < 5);
    chk(tag, int'(emptyN), 1);
  endtask

  task automatic rdWord();
    logic [DW-1:0] exp;
    waitData("R10 data available");
    if (fwftMode) chkData("R3 presented word", rdData, q[0]);
    rdEn = 1'b1;
    @(posedge rdClk);
    #1;
    rdEn = 1'b0;
    exp = q.pop_front();
    occ--;
    if (!fwftMode) chkData("R2 read word", rdData, exp);
    chk("R7 hfN after read", int'(hfN), hfExp());
    if (aeAsyncMode) chk("R8 aeN on read edge", int'(aeN), aeExp());
  endtask

  initial begin : watchdog
    #1_000_000;
    nFail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : stimulus
    // ---- standard style, dual-clock almost-empty, offset 3
    doReset(1'b0, 1'b1, 3);
    for (int i = 1; i <= DEPTH; i++) begin
      wrWord();
      if (i == DEPTH/2)     chk("R5 hfN high at D/2 writes", int'(hfN), 1);
      if (i == DEPTH/2 + 1) chk("R5 hfN low at D/2+1 writes", int'(hfN), 0);
    end
    repeat (10) @(posedge wrClk);
    wrWord();                                   // memory full: ignored
    for (int i = 0; i < DEPTH; i++) rdWord();
    repeat (10) @(posedge rdClk);
    #1;
    chk("R4 write into full memory not stored", int'(emptyN), 0);

    // read against empty buffer, then one word round trip
    @(negedge rdClk);
    rdEn = 1'b1;
    @(posedge rdClk);
    #1;
    rdEn = 1'b0;
    chk("R2 empty read leaves emptyN low", int'(emptyN), 0);
    wrWord();
    rdWord();                                   // checks R2 data order and R10

    // ---- partial reset keeps standard style
    for (int i = 0; i < 10; i++) wrWord();
    @(negedge rdClk);
    prstN = 1'b0;
    repeat (2) @(posedge rdClk);
    @(negedge rdClk);
    prstN = 1'b1;
    q.delete(); occ = 0;
    repeat (2) @(negedge rdClk);
    chk("R1 partial reset hfN", int'(hfN), 1);
    chk("R1 partial reset aeN", int'(aeN), 0);
    chk("R1 partial reset emptyN", int'(emptyN), 0);
    for (int i = 1; i <= DEPTH/2 + 1; i++) wrWord();
    chk("R1 style kept after partial reset", int'(hfN), 0);
    for (int i = 1; i <= DEPTH/2 + 1; i++) rdWord();

    // ---- fall-through style, read-clock-only almost-empty, offset 5
    doReset(1'b1, 1'b0, 5);
    wrWord();
    waitData("R10 first word falls through");
    chkData("R3 first word shown without request", rdData, q[0]);
    settleRd();
    chk("R9 aeN low at one word", int'(aeN), 0);
    for (int i = 2; i <= 12; i++) begin
      wrWord();
      if (i == 6) chk("R9 aeN unchanged right after write", int'(aeN), 0);
      if (i == DEPTH/2 + 1) chk("R6 hfN high at D/2+1 writes", int'(hfN), 1);
      if (i == DEPTH/2 + 2) chk("R6 hfN low at D/2+2 writes", int'(hfN), 0);
      settleRd();
      chk("R9 aeN settled after write", int'(aeN), aeExp());
    end
    for (int i = 0; i < 12; i++) begin
      rdWord();
      settleRd();
      chk("R9 aeN settled after read", int'(aeN), aeExp());
    end
    settleRd();
    chk("R3 emptyN low after last word", int'(emptyN), 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule